// File: doc/BRIEF.md
# Chroma Subcarrier Hue Phase Generator

This block produces the chroma subcarrier phase for a standard-definition composite video encoder. A 32-bit phase accumulator advances by a per-sample increment every clock. Two phases leave the block: the plain accumulator phase, which the burst path uses, and a shifted phase, which the chroma modulator uses. During active video the shifted phase carries a programmable hue rotation. At all other times it equals the plain phase. Hue is the phase difference between the active-video subcarrier and the colour burst, so the burst reference is never rotated.

The hue setting is an 8-bit excess-128 code. Each step is 1/2048 of a subcarrier cycle (0.17578125 degree), which gives about ±22.5 degrees of range. The code is captured once per line, on the rising edge of the burst gate, together with the enable bit and the standard bit. A write partway through a line therefore takes effect only on the next line. In PAL the lowest usable code is 0x01, so a PAL code of 0x00 is raised to 0x01. A flag reports a line whose effective code sits at the edge of the range.

Top module: `hue_phase_gen`

## Requirements
- R1: A synchronous active-low reset clears the accumulator, both phase outputs and the limit flag to zero.
- R2: `burst_phase` is a registered copy of the accumulator, and the accumulator adds `phase_inc` modulo 2^32 on every clock, so consecutive `burst_phase` values differ by the increment presented one clock earlier.
- R3: `burst_phase` never carries the hue rotation, whatever the code, enable, standard or video flags are.
- R4: `sc_phase` equals `burst_phase` when `active_video` was low at the previous edge, and equals `burst_phase` plus the line's rotation modulo 2^32 when it was high. The latency from `active_video` is one clock.
- R5: The rotation in phase units is (effective code − 128) × 2^21, so code 0x80 gives no rotation.
- R6: Code, enable and standard are captured only at an edge where `burst_gate` is high and was low at the previous edge. Changes at any other time do not affect the rotation or the limit flag.
- R7: If `hue_en` is low at the capture edge, the rotation for that line is zero and the limit flag is low.
- R8: With `pal_mode` high, a code of 0x00 is treated as 0x01 (rotation −127 × 2^21). With `pal_mode` low, 0x00 gives −128 × 2^21.
- R9: `hue_sat` is high from the capture edge until the next capture when the enable was high and the effective code was 0xFF, 0x00 in NTSC, or 0x01 in PAL. Otherwise it is low.
- R10: Code 0x97 rotates active video by +23 steps (0x02E00000, about +4.04 degrees), and 0x69 rotates it by −23 steps (0xFD200000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase_inc | input | 32 | Phase step added each sample |
| hue_en | input | 1 | Enables the hue rotation, captured per line |
| hue_code | input | 8 | Excess-128 hue code, captured per line |
| pal_mode | input | 1 | 1 = PAL lower limit, 0 = NTSC |
| burst_gate | input | 1 | High during the colour burst; its rising edge marks the start of a line |
| active_video | input | 1 | High during active picture samples |
| sc_phase | output | 32 | Subcarrier phase for the chroma modulator |
| burst_phase | output | 32 | Unrotated phase for the burst |
| hue_sat | output | 1 | The line's effective code is at a range limit |

## Verification
The hardest case to reach from the ports is a hue write that arrives partway through a line. It must leave the rest of that line untouched and then appear, exactly once, after the next burst edge. The stimulus changes `hue_code`, `hue_en` and `pal_mode` in the middle of active video on every line, while the behavioural model keeps the previous line's setting. The PAL 0x00 clamp and the accumulator wrap are reached by choosing those codes, and an increment near 2^32, on dedicated lines.

// File: rtl/hue_pkg.sv
// Shared constants for the hue phase generator.
// Assumes a subcarrier cycle divided into 2^HUE_STEPS_LOG2 hue steps.
package hue_pkg;
    localparam int HUE_STEPS_LOG2 = 11;
    localparam int PAL_MIN_CODE   = 1;
    localparam int NTSC_MIN_CODE  = 0;
endpackage

// File: rtl/hue_line_latch.sv
// Captures the hue setting once per line, at the rising edge of the burst gate.
// Applies the PAL lower clamp and the enable, and produces the signed step
// count plus the range-limit flag for the line.
// Assumes each line has exactly one burst pulse.
module hue_line_latch
    import hue_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     burst_gate,
    input  logic                     hue_en,
    input  logic [CODE_W-1:0]        hue_code,
    input  logic                     pal_mode,
    output logic signed [CODE_W:0]   off_steps,
    output logic                     line_sat
);
    localparam logic [CODE_W-1:0] CODE_MAX  = '1;
    localparam logic [CODE_W:0]   CODE_MID  = (CODE_W+1)'(1) << (CODE_W-1);
    localparam logic [CODE_W-1:0] PAL_LOW   = CODE_W'(PAL_MIN_CODE);
    localparam logic [CODE_W-1:0] NTSC_LOW  = CODE_W'(NTSC_MIN_CODE);

    logic              burst_d;
    logic              line_start;
    logic [CODE_W-1:0] code_eff;
    logic [CODE_W-1:0] code_low;
    logic signed [CODE_W:0] steps_nxt;
    logic              sat_nxt;

    // Detect the start of a line from the burst gate.
    always_ff @(posedge clk) begin
        if (!rst_n) burst_d <= 1'b0;
        else        burst_d <= burst_gate;
    end

    assign line_start = burst_gate & ~burst_d;

    // Apply the lower limit of the selected standard to the raw code.
    always_comb begin
        code_low = pal_mode ? PAL_LOW : NTSC_LOW;
        code_eff = (hue_code < code_low) ? code_low : hue_code;
    end

    // Turn the effective code into signed steps and a limit flag.
    always_comb begin
        if (hue_en) begin
            steps_nxt = $signed({1'b0, code_eff} - CODE_MID);
            sat_nxt   = (code_eff == CODE_MAX) || (code_eff == code_low);
        end else begin
            steps_nxt = '0;
            sat_nxt   = 1'b0;
        end
    end

    // Hold the line's setting until the next line start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_steps <= '0;
            line_sat  <= 1'b0;
        end else if (line_start) begin
            off_steps <= steps_nxt;
            line_sat  <= sat_nxt;
        end
    end
endmodule

// File: rtl/phase_accum.sv
// Free-running phase accumulator that wraps modulo 2^PHASE_W.
// Assumes phase_inc is valid on every clock (one sample per clock).
module phase_accum #(
    parameter int PHASE_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_inc,
    output logic [PHASE_W-1:0] acc
);
    // Advance the phase by one sample step.
    always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= acc + phase_inc;
    end
endmodule

// File: rtl/phase_out_stage.sv
// Registers the burst phase and the hue-rotated subcarrier phase.
// The rotation is applied only while active_video is high.
// Assumes off_steps is constant for the whole line.
module phase_out_stage
    import hue_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int CODE_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PHASE_W-1:0]     acc,
    input  logic signed [CODE_W:0] off_steps,
    input  logic                   active_video,
    output logic [PHASE_W-1:0]     sc_phase,
    output logic [PHASE_W-1:0]     burst_phase
);
    localparam int SHIFT = PHASE_W - HUE_STEPS_LOG2;
    localparam int EXT_W = PHASE_W - CODE_W - 1;

    logic [PHASE_W-1:0] off_ext;
    logic [PHASE_W-1:0] off_phase;
    logic [PHASE_W-1:0] sc_nxt;

    // Sign-extend the steps and scale them to phase units.
    generate
        if (EXT_W > 0) begin : g_ext
            assign off_ext = {{EXT_W{off_steps[CODE_W]}}, off_steps};
        end else begin : g_trunc
            assign off_ext = off_steps[PHASE_W-1:0];
        end
    endgenerate

    assign off_phase = off_ext << SHIFT;

    // Pick the rotated phase inside active video only.
    always_comb begin
        sc_nxt = active_video ? (acc + off_phase) : acc;
    end

    // Register both phase outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_phase    <= '0;
            burst_phase <= '0;
        end else begin
            sc_phase    <= sc_nxt;
            burst_phase <= acc;
        end
    end
endmodule

// File: rtl/hue_phase_gen.sv
// Top level of the chroma subcarrier hue phase generator: accumulator,
// per-line hue capture and output stage.
// Assumes one sample per clock, and that burst_gate rises once per line
// before active video.
module hue_phase_gen #(
    parameter int PHASE_W = 32,
    parameter int CODE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_inc,
    input  logic               hue_en,
    input  logic [CODE_W-1:0]  hue_code,
    input  logic               pal_mode,
    input  logic               burst_gate,
    input  logic               active_video,
    output logic [PHASE_W-1:0] sc_phase,
    output logic [PHASE_W-1:0] burst_phase,
    output logic               hue_sat
);
    logic [PHASE_W-1:0]     acc;
    logic signed [CODE_W:0] off_steps;

    phase_accum #(.PHASE_W(PHASE_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_inc (phase_inc),
        .acc       (acc)
    );

    hue_line_latch #(.CODE_W(CODE_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_gate (burst_gate),
        .hue_en     (hue_en),
        .hue_code   (hue_code),
        .pal_mode   (pal_mode),
        .off_steps  (off_steps),
        .line_sat   (hue_sat)
    );

    phase_out_stage #(.PHASE_W(PHASE_W), .CODE_W(CODE_W)) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc          (acc),
        .off_steps    (off_steps),
        .active_video (active_video),
        .sc_phase     (sc_phase),
        .burst_phase  (burst_phase)
    );
endmodule

// File: rtl/hue_phase_gen_chk.sv
// Assertion checker for hue_phase_gen, attached through bind.
// It keeps its own burst history and warm-up count, and reads only the ports.
module hue_phase_gen_chk #(
    parameter int PHASE_W = 32,
    parameter int CODE_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [PHASE_W-1:0] phase_inc,
    input logic               hue_en,
    input logic [CODE_W-1:0]  hue_code,
    input logic               pal_mode,
    input logic               burst_gate,
    input logic               active_video,
    input logic [PHASE_W-1:0] sc_phase,
    input logic [PHASE_W-1:0] burst_phase,
    input logic               hue_sat
);
    logic [1:0] warm;
    logic       bd;
    logic       rise_s;

    // Count clocks since reset, up to three.
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= '0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // Track the burst gate independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) bd <= 1'b0;
        else        bd <= burst_gate;
    end

    assign rise_s = burst_gate & ~bd;

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (sc_phase == '0 && burst_phase == '0 && !hue_sat));

    // R2
    accum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3) |-> (burst_phase == $past(burst_phase) + $past(phase_inc, 2)));

    // R4
    idle_unrotated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && !$past(active_video)) |-> (sc_phase == burst_phase));

    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm != 2'd0 && !$past(rise_s)) |-> $stable(hue_sat));

    // R6
    rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 2'd3 && $past(active_video) && $past(active_video, 2) && !$past(rise_s, 2))
        |-> ((sc_phase - burst_phase) == $past(sc_phase - burst_phase)));

    // R7
    disabled_no_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_s && !hue_en) |=> !hue_sat);
endmodule

bind hue_phase_gen hue_phase_gen_chk #(.PHASE_W(PHASE_W), .CODE_W(CODE_W)) u_chk (.*);

// File: tb/hue_phase_gen_bench.sv
module hue_phase_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] phase_inc = '0;
    logic        hue_en = 1'b0;
    logic [7:0]  hue_code = 8'h80;
    logic        pal_mode = 1'b0;
    logic        burst_gate = 1'b0;
    logic        active_video = 1'b0;
    logic [31:0] sc_phase;
    logic [31:0] burst_phase;
    logic        hue_sat;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R4";

    // Behavioural reference state.
    bit [31:0] m_acc, m_sc, m_bp, m_off;
    bit        m_sat, m_bd;

    always #10 clk = ~clk;

    hue_phase_gen u_hue_phase_gen (
        .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .hue_en(hue_en),
        .hue_code(hue_code), .pal_mode(pal_mode), .burst_gate(burst_gate),
        .active_video(active_video), .sc_phase(sc_phase),
        .burst_phase(burst_phase), .hue_sat(hue_sat)
    );

    // Reference model: updates on each rising edge from the pre-edge inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = 0; m_sc = 0; m_bp = 0; m_off = 0; m_sat = 0; m_bd = 0;
        end else begin
            m_bp = m_acc;
            m_sc = active_video ? m_acc + m_off : m_acc;
            if (burst_gate && !m_bd) begin
                int code;
                int low;
                low  = pal_mode ? 1 : 0;
                code = (int'(hue_code) < low) ? low : int'(hue_code);
                m_off = hue_en ? 32'((code - 128) * 2097152) : 32'd0;
                m_sat = hue_en && (code == 255 || code == low);
            end
            m_bd  = burst_gate;
            m_acc = m_acc + phase_inc;
        end
    end

    task automatic chk32(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk32("R3", "burst_phase", burst_phase, m_bp);
            chk32(cur_req, "sc_phase", sc_phase, m_sc);
            chk32("R9", "hue_sat", {31'd0, hue_sat}, {31'd0, m_sat});
        end
    end

    // One video line; the hue setting is disturbed in mid-line (R6).
    task automatic run_line(input logic [7:0] code, input logic en, input logic pal,
                            input logic [31:0] inc, input logic [31:0] exp_rot,
                            input string req);
        @(negedge clk);
        hue_code = code; hue_en = en; pal_mode = pal; phase_inc = inc;
        burst_gate = 1'b1;
        repeat (4) @(negedge clk);
        burst_gate = 1'b0;
        repeat (2) @(negedge clk);
        cur_req = req;
        active_video = 1'b1;
        repeat (3) @(negedge clk);
        hue_code = ~code; hue_en = ~en; pal_mode = ~pal;
        repeat (3) @(negedge clk);
        // Output now reflects an active sample: check the rotation directly.
        chk32(req, "rotation", sc_phase - burst_phase, exp_rot);
        repeat (4) @(negedge clk);
        active_video = 1'b0;
        repeat (3) @(negedge clk);
        cur_req = "R4";
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: still reset state just after release, before any increment.
        chk32("R1", "reset sc_phase", sc_phase, 32'd0);
        chk32("R1", "reset hue_sat", {31'd0, hue_sat}, 32'd0);
        run_line(8'h80, 1'b1, 1'b0, 32'h1234_5678, 32'h0000_0000, "R5");
        run_line(8'h97, 1'b1, 1'b0, 32'h21F0_7C1F, 32'h02E0_0000, "R10");
        run_line(8'h69, 1'b1, 1'b1, 32'h2A09_8ACB, 32'hFD20_0000, "R10");
        run_line(8'h00, 1'b1, 1'b1, 32'hF000_0001, 32'hF020_0000, "R8");
        run_line(8'h00, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'hF000_0000, "R8");
        run_line(8'hFF, 1'b1, 1'b0, 32'h8000_0003, 32'h0FE0_0000, "R9");
        run_line(8'h01, 1'b1, 1'b1, 32'h0000_0010, 32'hF020_0000, "R9");
        run_line(8'hC0, 1'b0, 1'b0, 32'h1111_1111, 32'h0000_0000, "R7");
        run_line(8'h3A, 1'b1, 1'b0, 32'h0F0F_0F0F, 32'hF740_0000, "R6");
        run_line(8'h81, 1'b1, 1'b1, 32'hFFFF_FFF0, 32'h0020_0000, "R2");
        // R1: reset in mid-run clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk32("R1", "mid reset burst_phase", burst_phase, 32'd0);
        chk32("R1", "mid reset sc_phase", sc_phase, 32'd0);
        rst_n = 1'b1;
        run_line(8'hA0, 1'b1, 1'b0, 32'h0400_0000, 32'h0400_0000, "R5");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule